// File: doc/BRIEF.md
# Halting and Retrying External Bus Sequencer

This block is a bus master that turns word requests from the core side into one or more strobed cycles on an external bus. The external port may be narrower than the word. Each external cycle raises an address strobe first and then a data strobe, and it ends when the slave returns a size code. That code states how many bytes the slave took or gave. The sequencer moves its address and byte offset forward by that amount until the whole word has been transferred. The core side uses a valid/ready request channel and receives a single-cycle response pulse that carries read data and an error flag.

Two slave-side inputs control the flow. The stall input keeps new external cycles from starting, but it never cuts off a cycle that is already running. If the stall input is held high and dropped for one cycle, the bus advances by exactly one cycle, which gives single-cycle stepping. The fault input ends a cycle. When it arrives alone, the request finishes with an error. When it arrives together with the stall input, the word transfer is rerun from its first byte once both inputs have gone low, even if some narrow pieces had already completed.

Top module: `bus_halt_retry_ctrl`

## Requirements
- R1: After reset, `bus_as`, `bus_ds` and `rsp_valid` are low, and `req_ready` is high while `bus_halt` is low.
- R2: The `bus_ack` code sets the width of each sub-access: 2'b01 is one byte, 2'b10 is two bytes, 2'b11 is the full 4-byte word, and 2'b00 means wait. The address advances by that width, so a word takes 4, 2 or 1 sub-accesses.
- R3: A narrow port uses the low byte lanes. On a write, the bytes starting at the current offset appear on `bus_wdata[8*w-1:0]`. On a read, the low `w` bytes of `bus_rdata` are placed at the current offset of `rsp_rdata`, with byte 0 of the word in bits [7:0].
- R4: While `bus_halt` is high, `req_ready` is low and no new cycle starts. `bus_as` does not rise at the next cycle boundary or later.
- R5: Raising `bus_halt` during a cycle does not end it. The strobes stay asserted until `bus_ack` or `bus_berr` arrives.
- R6: Dropping `bus_halt` for exactly one clock at a cycle boundary lets exactly one external cycle run, at the next sub-access address.
- R7: `bus_berr` and `bus_halt` sampled high together during the data strobe end the cycle as a retry. No response is given, and the whole word is rerun starting with the sub-access at offset 0.
- R8: After a retry, `bus_as` stays low until both `bus_berr` and `bus_halt` are low.
- R9: `bus_berr` without `bus_halt` ends the cycle and returns `rsp_valid` with `rsp_err` high. No further sub-access is made and no retry takes place.
- R10: Each cycle has one clock of `bus_as` alone, followed by `bus_as` and `bus_ds` until termination, followed by one clock with both low. `rsp_valid` pulses for one clock, one clock after that last idle-strobe clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word-aligned request address |
| req_wdata | input | DW | Write data, byte 0 in bits [7:0] |
| req_ready | output | 1 | Request accepted when high with req_valid |
| rsp_valid | output | 1 | One-clock completion pulse |
| rsp_err | output | 1 | Completion ended by a fault |
| rsp_rdata | output | DW | Assembled read data |
| bus_addr | output | AW | Current sub-access address |
| bus_wdata | output | DW | Write data shifted to the low lanes |
| bus_rdata | input | DW | Read data from the slave, low lanes |
| bus_read | output | 1 | 1 = read cycle |
| bus_as | output | 1 | Address strobe |
| bus_ds | output | 1 | Data strobe |
| bus_ack | input | 2 | Size acknowledge code |
| bus_berr | input | 1 | Fault termination |
| bus_halt | input | 1 | Stall / retry qualifier |

## Verification
Every input the slave model drives is sampled at the next rising edge while the data strobe is high. The strobe therefore drops one clock after an acknowledge, and the response pulse follows one clock after that. The bench drives and reads signals only on falling edges, and it makes each decision from the strobe values it sees at that falling edge. A halt raised or lowered at a falling edge affects the strobe seen at the next falling edge, and the step, stall and retry-wait checks are placed on exactly those edges.

// File: rtl/bhr_pkg.sv
package bhr_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_GAP,
      ST_S0,
      ST_S2,
      ST_S4,
      ST_RETRY,
      ST_RESP
   } seq_state_t;

   localparam logic [1:0] ACK_NONE = 2'b00;
   localparam logic [1:0] ACK_BYTE = 2'b01;
   localparam logic [1:0] ACK_HALF = 2'b10;
   localparam logic [1:0] ACK_WORD = 2'b11;

endpackage

// File: rtl/bhr_lane_unit.sv
module bhr_lane_unit
   import bhr_pkg::*;
#(
   parameter int DW = 32,
   localparam int BYTES = DW / 8,
   localparam int OFFW = $clog2(BYTES)
) (
   input  logic [OFFW-1:0] off,
   input  logic [1:0]      ack,
   input  logic [DW-1:0]   wdata,
   input  logic [DW-1:0]   bus_rdata,
   input  logic [DW-1:0]   rbuf,
   output logic [OFFW:0]   step,
   output logic [DW-1:0]   bus_wdata,
   output logic [DW-1:0]   rbuf_next
);

   always_comb begin
      unique case (ack)
         ACK_BYTE: step = (OFFW+1)'(1);
         ACK_HALF: step = (OFFW+1)'(2);
         ACK_WORD: step = (OFFW+1)'(BYTES);
         default:  step = '0;
      endcase
   end

   // Bytes from the current offset upward go out on the low lanes.
   assign bus_wdata = wdata >> {off, 3'b000};

   // Each word byte looks back at the low lane that feeds it on this sub-access.
   for (genvar i = 0; i < BYTES; i++) begin : g_lane
      logic [OFFW:0] rel;
      logic          hit;
      always_comb begin
         rel = (OFFW+1)'(i) - {1'b0, off};
         hit = ((OFFW+1)'(i) >= {1'b0, off}) && (rel < step);
      end
      assign rbuf_next[8*i +: 8] = hit ? 8'(bus_rdata >> {rel, 3'b000})
                                       : rbuf[8*i +: 8];
   end

endmodule

// File: rtl/bhr_sequencer.sv
module bhr_sequencer
   import bhr_pkg::*;
#(
   parameter int AW = 32,
   parameter int DW = 32,
   localparam int BYTES = DW / 8,
   localparam int OFFW = $clog2(BYTES)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_valid,
   input  logic            req_write,
   input  logic [AW-1:0]   req_addr,
   input  logic [DW-1:0]   req_wdata,
   output logic            req_ready,
   output logic            rsp_valid,
   output logic            rsp_err,
   output logic [DW-1:0]   rsp_rdata,
   output logic [AW-1:0]   bus_addr,
   output logic            bus_read,
   output logic            bus_as,
   output logic            bus_ds,
   input  logic [1:0]      bus_ack,
   input  logic            bus_berr,
   input  logic            bus_halt,
   output logic [OFFW-1:0] off_o,
   input  logic [OFFW:0]   step_i,
   input  logic [DW-1:0]   rbuf_next_i,
   output logic [DW-1:0]   rbuf_o,
   output logic [DW-1:0]   wdata_o
);

   seq_state_t      state_q;
   logic [AW-1:0]   base_q;
   logic            write_q;
   logic [DW-1:0]   wdata_q;
   logic [DW-1:0]   rbuf_q;
   logic [OFFW-1:0] off_q;
   logic            err_q;
   logic            last_q;
   logic [OFFW+1:0] off_sum;

   assign off_sum = {2'b00, off_q} + {1'b0, step_i};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         base_q  <= '0;
         write_q <= 1'b0;
         wdata_q <= '0;
         rbuf_q  <= '0;
         off_q   <= '0;
         err_q   <= 1'b0;
         last_q  <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (req_valid && !bus_halt) begin
                  base_q  <= req_addr;
                  write_q <= req_write;
                  wdata_q <= req_wdata;
                  rbuf_q  <= '0;
                  off_q   <= '0;
                  err_q   <= 1'b0;
                  last_q  <= 1'b0;
                  state_q <= ST_S0;
               end
            end
            ST_GAP: if (!bus_halt) state_q <= ST_S0;
            ST_S0:  state_q <= ST_S2;
            ST_S2: begin
               if (bus_berr && bus_halt) begin
                  off_q   <= '0;
                  rbuf_q  <= '0;
                  state_q <= ST_RETRY;
               end else if (bus_berr) begin
                  err_q   <= 1'b1;
                  state_q <= ST_S4;
               end else if (bus_ack != ACK_NONE) begin
                  if (!write_q) rbuf_q <= rbuf_next_i;
                  last_q  <= (off_sum >= (OFFW+2)'(BYTES));
                  off_q   <= off_sum[OFFW-1:0];
                  state_q <= ST_S4;
               end
            end
            ST_S4:    state_q <= (err_q || last_q) ? ST_RESP : ST_GAP;
            ST_RETRY: if (!bus_berr && !bus_halt) state_q <= ST_S0;
            ST_RESP:  state_q <= ST_IDLE;
            default:  state_q <= ST_IDLE;
         endcase
      end
   end

   assign req_ready = (state_q == ST_IDLE) && !bus_halt;
   assign rsp_valid = (state_q == ST_RESP);
   assign rsp_err   = err_q;
   assign rsp_rdata = rbuf_q;
   assign bus_addr  = base_q + AW'(off_q);
   assign bus_read  = !write_q;
   assign bus_as    = (state_q == ST_S0) || (state_q == ST_S2);
   assign bus_ds    = (state_q == ST_S2);
   assign off_o     = off_q;
   assign rbuf_o    = rbuf_q;
   assign wdata_o   = wdata_q;

   // R10: data strobe only inside address strobe; address phase lasts one clock
   p_ds_inside_as_r10: assert property (@(posedge clk) disable iff (!rst_n)
      bus_ds |-> bus_as);
   p_s0_then_s2_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_as && !bus_ds) |=> bus_ds);
   // R4: a cycle starts only after halt was sampled low
   p_start_needs_go_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_as) |-> !$past(bus_halt));
   p_ready_low_halt_r4: assert property (@(posedge clk) disable iff (!rst_n)
      bus_halt |-> !req_ready);
   // R5: halt by itself never ends a running cycle
   p_halt_keeps_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_ds && bus_halt && !bus_berr && bus_ack == ACK_NONE) |=> bus_ds);
   // R7: retry ends the cycle without a response
   p_retry_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_ds && bus_berr && bus_halt) |=> (!bus_as && !rsp_valid));
   // R8: no rerun while either qualifier stays high
   p_retry_wait_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RETRY && (bus_berr || bus_halt)) |=> !bus_as);
   // R9: lone fault reports an error two clocks later
   p_fault_reports_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_ds && bus_berr && !bus_halt) |=> ##1 (rsp_valid && rsp_err));

endmodule

// File: rtl/bus_halt_retry_ctrl.sv
module bus_halt_retry_ctrl
   import bhr_pkg::*;
#(
   parameter int AW = 32,
   parameter int DW = 32,
   localparam int BYTES = DW / 8,
   localparam int OFFW = $clog2(BYTES)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic          req_write,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_wdata,
   output logic          req_ready,
   output logic          rsp_valid,
   output logic          rsp_err,
   output logic [DW-1:0] rsp_rdata,
   output logic [AW-1:0] bus_addr,
   output logic [DW-1:0] bus_wdata,
   input  logic [DW-1:0] bus_rdata,
   output logic          bus_read,
   output logic          bus_as,
   output logic          bus_ds,
   input  logic [1:0]    bus_ack,
   input  logic          bus_berr,
   input  logic          bus_halt
);

   if (DW < 16 || (DW % 8) != 0 || (BYTES & (BYTES - 1)) != 0) begin : g_bad_dw
      $error("bus_halt_retry_ctrl: DW must be a power-of-two byte count of at least 16 bits");
   end
   if (AW <= OFFW) begin : g_bad_aw
      $error("bus_halt_retry_ctrl: AW must exceed the byte offset width");
   end

   logic [OFFW-1:0] off;
   logic [OFFW:0]   step;
   logic [DW-1:0]   rbuf;
   logic [DW-1:0]   rbuf_next;
   logic [DW-1:0]   wdata;

   bhr_sequencer #(.AW(AW), .DW(DW)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid   (req_valid),
      .req_write   (req_write),
      .req_addr    (req_addr),
      .req_wdata   (req_wdata),
      .req_ready   (req_ready),
      .rsp_valid   (rsp_valid),
      .rsp_err     (rsp_err),
      .rsp_rdata   (rsp_rdata),
      .bus_addr    (bus_addr),
      .bus_read    (bus_read),
      .bus_as      (bus_as),
      .bus_ds      (bus_ds),
      .bus_ack     (bus_ack),
      .bus_berr    (bus_berr),
      .bus_halt    (bus_halt),
      .off_o       (off),
      .step_i      (step),
      .rbuf_next_i (rbuf_next),
      .rbuf_o      (rbuf),
      .wdata_o     (wdata)
   );

   bhr_lane_unit #(.DW(DW)) u_lane (
      .off       (off),
      .ack       (bus_ack),
      .wdata     (wdata),
      .bus_rdata (bus_rdata),
      .rbuf      (rbuf),
      .step      (step),
      .bus_wdata (bus_wdata),
      .rbuf_next (rbuf_next)
   );

endmodule

// File: tb/bus_halt_retry_ctrl_tb.sv
`timescale 1ns/1ps
module bus_halt_retry_ctrl_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [31:0] req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic        req_ready;
   logic        rsp_valid;
   logic        rsp_err;
   logic [31:0] rsp_rdata;
   logic [31:0] bus_addr;
   logic [31:0] bus_wdata;
   logic [31:0] bus_rdata = '0;
   logic        bus_read;
   logic        bus_as;
   logic        bus_ds;
   logic [1:0]  bus_ack = 2'b00;
   logic        bus_berr = 1'b0;
   logic        bus_halt = 1'b0;

   int checks = 0;
   int failures = 0;

   logic [7:0]  wmem [0:15];
   int          sub, ds_cnt, s0_cnt, rp;
   bit          retried, logged, done, got_err;
   logic [31:0] got_rdata, retry_addr;

   always #2.5 clk = ~clk;

   bus_halt_retry_ctrl u_dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
      .req_wdata(req_wdata), .req_ready(req_ready),
      .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .bus_read(bus_read), .bus_as(bus_as), .bus_ds(bus_ds),
      .bus_ack(bus_ack), .bus_berr(bus_berr), .bus_halt(bus_halt)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] pat(input logic [31:0] a);
      return a[7:0] ^ 8'hA5;
   endfunction

   function automatic logic [31:0] rd_resp(input logic [31:0] a, input int pw);
      logic [31:0] r = '0;
      for (int k = 0; k < 4; k++) if (k < pw) r[8*k +: 8] = pat(a + k);
      return r;
   endfunction

   function automatic logic [31:0] rd_word(input logic [31:0] a);
      return {pat(a + 3), pat(a + 2), pat(a + 1), pat(a)};
   endfunction

   function automatic logic [1:0] code(input int pw);
      return (pw == 1) ? 2'b01 : (pw == 2) ? 2'b10 : 2'b11;
   endfunction

   task automatic give_ack(input int pw);
      bus_ack   = code(pw);
      bus_rdata = rd_resp(bus_addr, pw);
      if (!bus_read)
         for (int k = 0; k < pw; k++) wmem[(bus_addr + k) & 15] = bus_wdata[8*k +: 8];
   endtask

   task automatic issue(input bit wr, input logic [31:0] a, input logic [31:0] wd);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
      for (int i = 0; i < 50 && !req_ready; i++) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   // Slave model: inspects at each falling edge, answers each data strobe at once.
   task automatic serve(input int pw, input int retry_at, input int err_at, input bit hold_berr);
      done = 1'b0;
      for (int i = 0; i < 300 && !done; i++) begin
         bus_ack = 2'b00;
         if (rp > 0) begin
            chk(!bus_as, "R8 no strobe while retry pending", 32'(bus_as), 0);
            rp--;
            if (rp == 0) begin bus_halt = 1'b0; bus_berr = 1'b0; end
            else if (rp == 3) begin bus_halt = !hold_berr; bus_berr = hold_berr; end
         end else bus_berr = 1'b0;
         if (rsp_valid) begin
            got_err = rsp_err; got_rdata = rsp_rdata; done = 1'b1;
         end else begin
            if (bus_as && !bus_ds) s0_cnt++;
            if (bus_ds) begin
               ds_cnt++;
               if (retried && !logged) begin retry_addr = bus_addr; logged = 1'b1; end
               if (sub == err_at) bus_berr = 1'b1;
               else if (sub == retry_at && !retried) begin
                  bus_berr = 1'b1; bus_halt = 1'b1; retried = 1'b1; rp = 4;
               end else begin
                  give_ack(pw); sub++;
               end
            end
            @(negedge clk);
         end
      end
      chk(done, "R10 response arrives", 32'(done), 1);
   endtask

   task automatic reset_vars();
      sub = 0; ds_cnt = 0; s0_cnt = 0; rp = 0;
      retried = 0; logged = 0; got_err = 0; got_rdata = '0; retry_addr = '0;
      for (int k = 0; k < 16; k++) wmem[k] = 8'h00;
   endtask

   task automatic run_access(input bit wr, input logic [31:0] a, input logic [31:0] wd,
                             input int pw, input int retry_at, input int err_at, input bit hold_berr);
      reset_vars();
      issue(wr, a, wd);
      serve(pw, retry_at, err_at, hold_berr);
      chk(s0_cnt == ds_cnt, "R10 one address phase per data phase", 32'(s0_cnt), 32'(ds_cnt));
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk(!bus_as && !bus_ds, "R1 strobes low after reset", {30'b0, bus_as, bus_ds}, 0);
      chk(!rsp_valid, "R1 no response after reset", 32'(rsp_valid), 0);
      chk(req_ready, "R1 ready after reset", 32'(req_ready), 1);
   endtask

   task automatic t_read(input int pw, input logic [31:0] a);
      run_access(1'b0, a, '0, pw, -1, -1, 1'b0);
      chk(sub == 4 / pw, "R2 sub-access count for port width", 32'(sub), 32'(4 / pw));
      chk(got_rdata == rd_word(a), "R3 read data assembly", got_rdata, rd_word(a));
      chk(!got_err, "R9 no error on clean read", 32'(got_err), 0);
   endtask

   task automatic t_write(input int pw, input logic [31:0] a, input logic [31:0] wd);
      logic [31:0] seen;
      run_access(1'b1, a, wd, pw, -1, -1, 1'b0);
      seen = {wmem[(a + 3) & 15], wmem[(a + 2) & 15], wmem[(a + 1) & 15], wmem[a & 15]};
      chk(sub == 4 / pw, "R2 write sub-access count", 32'(sub), 32'(4 / pw));
      chk(seen == wd, "R3 write lane data", seen, wd);
   endtask

   task automatic t_retry(input bit hold_berr);
      logic [31:0] a = 32'h0000_0120;
      run_access(1'b0, a, '0, 1, 2, -1, hold_berr);
      chk(!got_err, "R7 retry reports no error", 32'(got_err), 0);
      chk(retry_addr == a, "R7 rerun starts at first sub-access", retry_addr, a);
      chk(sub == 6, "R7 whole word rerun", 32'(sub), 6);
      chk(got_rdata == rd_word(a), "R7 data after retry", got_rdata, rd_word(a));
   endtask

   task automatic t_fault();
      run_access(1'b0, 32'h0000_0140, '0, 2, -1, 1, 1'b0);
      chk(got_err, "R9 lone fault gives error", 32'(got_err), 1);
      chk(sub == 1 && ds_cnt == 2, "R9 no further sub-access", 32'(ds_cnt), 2);
   endtask

   task automatic t_halt_stall();
      @(negedge clk);
      bus_halt = 1'b1; req_valid = 1'b1; req_write = 1'b0; req_addr = 32'h0000_0160;
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         chk(!req_ready && !bus_as, "R4 halted: no ready, no strobe", {30'b0, req_ready, bus_as}, 0);
      end
      req_valid = 1'b0;
      @(negedge clk);
      bus_halt = 1'b0;
      @(negedge clk);
      chk(!bus_as && !rsp_valid, "R4 nothing accepted while halted", 32'(bus_as), 0);
   endtask

   task automatic t_halt_step();
      logic [31:0] a = 32'h0000_0180;
      logic [31:0] wd = 32'hC3B2_A190;
      logic [31:0] seen;
      reset_vars();
      issue(1'b1, a, wd);
      @(negedge clk);
      chk(bus_ds, "R10 data phase follows address phase", 32'(bus_ds), 1);
      bus_halt = 1'b1;
      for (int i = 0; i < 2; i++) begin
         @(negedge clk);
         chk(bus_ds, "R5 halt does not end running cycle", 32'(bus_ds), 1);
      end
      give_ack(1);
      @(negedge clk);
      bus_ack = 2'b00;
      chk(!bus_ds, "R5 cycle ends on acknowledge", 32'(bus_ds), 0);
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         chk(!bus_as, "R4 stall at cycle boundary", 32'(bus_as), 0);
      end
      bus_halt = 1'b0;
      @(negedge clk);
      bus_halt = 1'b1;
      chk(bus_as && bus_addr == a + 1, "R6 stepped cycle at next address", bus_addr, a + 1);
      @(negedge clk);
      give_ack(1);
      @(negedge clk);
      bus_ack = 2'b00;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         chk(!bus_as, "R6 only one cycle per step", 32'(bus_as), 0);
      end
      bus_halt = 1'b0;
      sub = 2;
      serve(1, -1, -1, 1'b0);
      chk(sub == 4, "R2 byte port needs four sub-accesses", 32'(sub), 4);
      seen = {wmem[(a + 3) & 15], wmem[(a + 2) & 15], wmem[(a + 1) & 15], wmem[a & 15]};
      chk(seen == wd, "R3 stepped write data", seen, wd);
   endtask

   initial begin
      #(200000 * 5);
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_read(4, 32'h0000_0040);
      t_read(2, 32'h0000_0084);
      t_read(1, 32'h0000_0088);
      t_write(2, 32'h0000_0090, 32'h1234_5678);
      t_write(1, 32'h0000_00A4, 32'hDEAD_BEEF);
      t_write(4, 32'h0000_00B8, 32'h0F1E_2D3C);
      t_retry(1'b0);
      t_retry(1'b1);
      t_fault();
      t_halt_stall();
      t_halt_step();
      repeat (3) @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule